// File: doc/BRIEF.md
# Stripe-Scan Coefficient Address Generator with Code-Block Switching

This block walks a rectangular code-block in the scan order used for bit-plane coding. It produces one coefficient read address per cycle for the selected code-block. Each stripe is four rows tall and as wide as the code-block. The stripe is traversed one column at a time, left to right, and each column is read from its upper row down. A single start command runs exactly one stripe and then stops. The caller may then start the next stripe of the same code-block, or move to any other code-block slot. Blocks can therefore be interleaved stripe by stripe, and each slot continues where it left off.

The block holds one row store and one stripe counter per slot. While the scan is in the bottom row of a stripe, the coefficient value presented on `coefIn` is saved at its column. During the following stripe of that slot, the saved value comes back on `nbrVal` as the upper neighbour of the same column. On the first stripe of a block, the neighbour reads as zero. Four slots are narrow (up to 32 columns) and nine are wide (up to 64 columns). When a code-block set has finished, a later set reuses the same slots by starting with `fresh` set.

Top module: `stripe_scan_agen`

## Requirements
- R1: After reset, `coefValid` and `stripeDone` are 0. Every slot's stripe counter is 0.
- R2: A start is accepted when the block is idle and the request is valid. On acceptance, the following cycle presents column 0, stripe row 0. Each later cycle steps down the column (stripe rows 0 to 3), then moves to row 0 of the next column. The scan covers exactly 4 × width coefficients.
- R3: `coefAddr` = `rowIdx` × width + `colIdx`, where `rowIdx` = 4 × stripe index + stripe row (rows counted from 0 at the top of the code-block).
- R4: `firstRow` is 1 exactly on stripe row 0 and `lastRow` is 1 exactly on stripe row 3. Both are 0 when `coefValid` is 0.
- R5: `stripeDone` is a one-cycle pulse in the cycle after the bottom coefficient of the rightmost column. In that cycle, `coefValid` is 0.
- R6: Each slot keeps its own stripe index. An accepted start with `fresh`=0 runs that slot's next stripe. With `fresh`=1, it runs stripe 0. After the last stripe (index CB_HEIGHT/4 − 1 = 15), the index wraps to 0.
- R7: On stripe 0 of a slot, `nbrVal` is 0 for every coefficient.
- R8: On later stripes, `nbrVal` equals the `coefIn` value that was presented on stripe row 3 of the same column during that slot's previous stripe. Stripes of other slots run in between do not alter it.
- R9: A start raised while a stripe is being scanned is ignored. The scan in progress and the target slot's state are unchanged.
- R10: A start is ignored, with `coefValid` staying 0 and no slot state changing, in any of these cases: `cbSel` ≥ 13, width 0, width above 32 on slots 0–3, or width above 64 on slots 4–12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to scan one stripe |
| fresh | input | 1 | Begin the selected slot at stripe 0 |
| cbSel | input | 4 | Code-block slot index |
| cbWidth | input | 7 | Code-block width in columns |
| coefIn | input | 12 | Value of the coefficient currently addressed |
| coefValid | output | 1 | Address and indices are valid this cycle |
| coefAddr | output | 12 | Coefficient address inside the code-block |
| rowIdx | output | 6 | Row index inside the code-block |
| colIdx | output | 6 | Column index |
| firstRow | output | 1 | Top row of the stripe |
| lastRow | output | 1 | Bottom row of the stripe |
| nbrVal | output | 12 | Saved upper-neighbour value for this column |
| stripeDone | output | 1 | One-cycle end-of-stripe pulse |

## Verification
The assertions run on every cycle. They check the column-major stepping of the scan, the exclusive row flags, and that `stripeDone` lasts one cycle, follows the bottom coefficient, and leaves the block idle. They also check that an accepted request always carries a width the selected slot can hold. The addresses, the per-slot stripe progression and wrap, the `fresh` restart, and the neighbour values carried across interleaved code-blocks depend on history spanning many stripes. Only the bench scenarios show these, by comparing against a model of each slot's store and stripe index. The same applies to rejected and mid-scan starts leaving all state untouched.

// File: rtl/stripe_scan_pkg.sv
package stripe_scan_pkg;
  localparam int NUM_SLOTS  = 13;
  localparam int NUM_NARROW = 4;
  localparam int NARROW_W   = 32;
  localparam int WIDE_W     = 64;
  localparam int DATA_W     = 12;
  localparam int CB_HEIGHT  = 64;

  localparam int STRIPES = CB_HEIGHT / 4;
  localparam int SEL_W   = $clog2(NUM_SLOTS);
  localparam int WID_W   = $clog2(WIDE_W + 1);
  localparam int COL_W   = $clog2(WIDE_W);
  localparam int STR_W   = $clog2(STRIPES);
  localparam int ROW_W   = STR_W + 2;
  localparam int ADDR_W  = $clog2(WIDE_W * CB_HEIGHT);

  typedef struct packed {
    logic             active;
    logic             wrEn;
    logic             firstStripe;
    logic [SEL_W-1:0] slot;
    logic [WID_W-1:0] width;
    logic [COL_W-1:0] col;
    logic [1:0]       row;
    logic [STR_W-1:0] stripe;
  } scanCtlT;

  function automatic int slotCapacity(int s);
    return (s < NUM_NARROW) ? NARROW_W : WIDE_W;
  endfunction
endpackage

// File: rtl/stripe_scan_ctrl.sv
module stripe_scan_ctrl
  import stripe_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             fresh,
  input  logic [SEL_W-1:0] cbSel,
  input  logic [WID_W-1:0] cbWidth,
  output scanCtlT          ctl,
  output logic             stripeDone
);
  logic             activeR;
  logic [SEL_W-1:0] slotR;
  logic [WID_W-1:0] widthR;
  logic [COL_W-1:0] colR;
  logic [1:0]       rowR;
  logic             doneR;
  logic [STR_W-1:0] stripeCnt [NUM_SLOTS];

  logic reqOk;
  logic accept;
  logic lastCoef;
  logic [STR_W-1:0] curStripe;

  always_comb begin
    reqOk = 1'b0;
    if (int'(cbSel) < NUM_SLOTS && cbWidth != '0 &&
        int'(cbWidth) <= slotCapacity(int'(cbSel)))
      reqOk = 1'b1;
  end

  assign accept   = start && !activeR && reqOk;
  assign lastCoef = activeR && rowR == 2'd3 && colR == COL_W'(widthR - 1'b1);

  always_comb begin
    curStripe = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slotR == SEL_W'(s)) curStripe = stripeCnt[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeR <= 1'b0;
      slotR   <= '0;
      widthR  <= '0;
      colR    <= '0;
      rowR    <= '0;
      doneR   <= 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) stripeCnt[s] <= '0;
    end else begin
      doneR <= lastCoef;
      if (accept) begin
        activeR <= 1'b1;
        slotR   <= cbSel;
        widthR  <= cbWidth;
        colR    <= '0;
        rowR    <= '0;
        if (fresh) begin
          for (int s = 0; s < NUM_SLOTS; s++)
            if (cbSel == SEL_W'(s)) stripeCnt[s] <= '0;
        end
      end else if (activeR) begin
        if (rowR == 2'd3) begin
          rowR <= '0;
          if (lastCoef) begin
            activeR <= 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++)
              if (slotR == SEL_W'(s))
                stripeCnt[s] <= (curStripe == STR_W'(STRIPES - 1)) ? '0 : curStripe + 1'b1;
          end else begin
            colR <= colR + 1'b1;
          end
        end else begin
          rowR <= rowR + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.active      = activeR;
    ctl.wrEn        = activeR && rowR == 2'd3;
    ctl.firstStripe = curStripe == '0;
    ctl.slot        = slotR;
    ctl.width       = widthR;
    ctl.col         = colR;
    ctl.row         = rowR;
    ctl.stripe      = curStripe;
  end

  assign stripeDone = doneR;
endmodule

// File: rtl/stripe_scan_dpath.sv
module stripe_scan_dpath
  import stripe_scan_pkg::*;
(
  input  logic              clk,
  input  scanCtlT           ctl,
  input  logic [DATA_W-1:0] coefIn,
  output logic [ADDR_W-1:0] coefAddr,
  output logic [ROW_W-1:0]  rowIdx,
  output logic [DATA_W-1:0] nbrVal
);
  logic [DATA_W-1:0] slotRd [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    localparam int SW = (s < NUM_NARROW) ? NARROW_W : WIDE_W;
    localparam int IW = $clog2(SW);
    logic [DATA_W-1:0] rowMem [SW];
    logic [IW-1:0]     idx;
    assign idx = ctl.col[IW-1:0];
    always_ff @(posedge clk) begin
      if (ctl.wrEn && ctl.slot == SEL_W'(s)) rowMem[idx] <= coefIn;
    end
    assign slotRd[s] = rowMem[idx];
  end

  logic [DATA_W-1:0] selRd;
  always_comb begin
    selRd = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (ctl.slot == SEL_W'(s)) selRd = slotRd[s];
  end

  assign rowIdx   = {ctl.stripe, ctl.row};
  assign coefAddr = ctl.active ?
                    ADDR_W'(rowIdx) * ADDR_W'(ctl.width) + ADDR_W'(ctl.col) : '0;
  assign nbrVal   = (ctl.active && !ctl.firstStripe) ? selRd : '0;
endmodule

// File: rtl/stripe_scan_agen.sv
module stripe_scan_agen
  import stripe_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fresh,
  input  logic [SEL_W-1:0]  cbSel,
  input  logic [WID_W-1:0]  cbWidth,
  input  logic [DATA_W-1:0] coefIn,
  output logic              coefValid,
  output logic [ADDR_W-1:0] coefAddr,
  output logic [ROW_W-1:0]  rowIdx,
  output logic [COL_W-1:0]  colIdx,
  output logic              firstRow,
  output logic              lastRow,
  output logic [DATA_W-1:0] nbrVal,
  output logic              stripeDone
);
  scanCtlT ctl;

  stripe_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fresh(fresh),
    .cbSel(cbSel), .cbWidth(cbWidth), .ctl(ctl), .stripeDone(stripeDone)
  );

  stripe_scan_dpath u_dpath (
    .clk(clk), .ctl(ctl), .coefIn(coefIn),
    .coefAddr(coefAddr), .rowIdx(rowIdx), .nbrVal(nbrVal)
  );

  assign coefValid = ctl.active;
  assign colIdx    = ctl.active ? ctl.col : '0;
  assign firstRow  = ctl.active && ctl.row == 2'd0;
  assign lastRow   = ctl.active && ctl.row == 2'd3;
endmodule

// File: rtl/stripe_scan_agen_chk.sv
module stripe_scan_agen_chk
  import stripe_scan_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             coefValid,
  input logic [ROW_W-1:0] rowIdx,
  input logic [COL_W-1:0] colIdx,
  input logic             firstRow,
  input logic             lastRow,
  input logic             stripeDone,
  input scanCtlT          ctl
);
  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({firstRow, lastRow}) && (coefValid || (!firstRow && !lastRow)));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    coefValid && !lastRow |=> coefValid && colIdx == $past(colIdx) &&
                              rowIdx == $past(rowIdx) + 1'b1);

  assert_next_column_R2: assert property (@(posedge clk) disable iff (!rstN)
    coefValid && lastRow |=> stripeDone ||
                             (coefValid && firstRow && colIdx == $past(colIdx) + 1'b1));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    stripeDone |=> !stripeDone);

  assert_done_after_bottom_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stripeDone) |-> !coefValid && $past(coefValid && lastRow));

  assert_width_fits_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coefValid) |-> ctl.width != '0 &&
                         int'(ctl.width) <= slotCapacity(int'(ctl.slot)));
endmodule

bind stripe_scan_agen stripe_scan_agen_chk u_chk (
  .clk(clk), .rstN(rstN), .coefValid(coefValid), .rowIdx(rowIdx),
  .colIdx(colIdx), .firstRow(firstRow), .lastRow(lastRow),
  .stripeDone(stripeDone), .ctl(ctl)
);

// File: tb/sim_stripe_scan_agen.sv
module sim_stripe_scan_agen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, fresh = 1'b0;
  logic [3:0]  cbSel = '0;
  logic [6:0]  cbWidth = '0;
  logic [11:0] coefIn = '0;
  logic        coefValid, firstRow, lastRow, stripeDone;
  logic [11:0] coefAddr, nbrVal;
  logic [5:0]  rowIdx, colIdx;

  int nChecks = 0, nFails = 0;
  int stripeM [13];
  int widthM  [13];
  bit initM   [13];
  logic [11:0] storeM [13][64];

  always #5 clk = ~clk;

  stripe_scan_agen u0 (
    .clk(clk), .rstN(rstN), .start(start), .fresh(fresh), .cbSel(cbSel),
    .cbWidth(cbWidth), .coefIn(coefIn), .coefValid(coefValid),
    .coefAddr(coefAddr), .rowIdx(rowIdx), .colIdx(colIdx),
    .firstRow(firstRow), .lastRow(lastRow), .nbrVal(nbrVal),
    .stripeDone(stripeDone)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int capOf(int s);
    return (s < 4) ? 32 : 64;
  endfunction

  // Run one stripe of slot sel; optionally inject a start while busy (R9).
  task automatic runStripe(int sel, int w, bit fr, bit injectBusy);
    int st;
    @(negedge clk);
    start = 1'b1; cbSel = 4'(sel); cbWidth = 7'(w); fresh = fr;
    @(negedge clk);
    start = 1'b0; fresh = 1'b0;
    if (fr) stripeM[sel] = 0;
    st = stripeM[sel];
    for (int c = 0; c < w; c++) begin
      for (int r = 0; r < 4; r++) begin
        int expRow = st * 4 + r;
        int expAddr = expRow * w + c;
        int expNbr = (st == 0) ? 0 : int'(storeM[sel][c]);
        check(coefValid === 1'b1, "R2", "coefValid", int'(coefValid), 1);
        check(colIdx == 6'(c) && rowIdx == 6'(expRow), "R2", "row*64+col",
              int'(rowIdx) * 64 + int'(colIdx), expRow * 64 + c);
        check(coefAddr == 12'(expAddr), "R3", "coefAddr", int'(coefAddr), expAddr);
        check(firstRow == (r == 0) && lastRow == (r == 3), "R4", "flags",
              int'({firstRow, lastRow}), int'({r == 0, r == 3}));
        if (st == 0)
          check(nbrVal == 12'd0, "R7", "nbrVal first stripe", int'(nbrVal), 0);
        else
          check(nbrVal == 12'(expNbr), "R8", "nbrVal", int'(nbrVal), expNbr);
        coefIn = 12'($urandom);
        if (r == 3) storeM[sel][c] = coefIn;
        if (injectBusy && c == 0 && r == 1) begin
          start = 1'b1; fresh = 1'b1; cbSel = 4'((sel + 1) % 13); cbWidth = 7'd5;
        end else begin
          start = 1'b0; fresh = 1'b0;
        end
        @(negedge clk);
      end
    end
    check(stripeDone === 1'b1 && coefValid === 1'b0, "R5", "done cycle",
          int'({stripeDone, coefValid}), 2);
    stripeM[sel] = (st == 15) ? 0 : st + 1;
    @(negedge clk);
    check(stripeDone === 1'b0 && coefValid === 1'b0, "R5", "pulse length",
          int'({stripeDone, coefValid}), 0);
  endtask

  task automatic badStart(int sel, int w);
    @(negedge clk);
    start = 1'b1; cbSel = 4'(sel); cbWidth = 7'(w); fresh = 1'b1;
    @(negedge clk);
    start = 1'b0; fresh = 1'b0;
    check(coefValid === 1'b0, "R10", "rejected start", int'(coefValid), 0);
    @(negedge clk);
    check(coefValid === 1'b0 && stripeDone === 1'b0, "R10", "still idle",
          int'({coefValid, stripeDone}), 0);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < 13; s++) begin stripeM[s] = 0; initM[s] = 0; widthM[s] = 1; end
    repeat (3) @(negedge clk);
    check(coefValid === 1'b0 && stripeDone === 1'b0, "R1", "reset outputs",
          int'({coefValid, stripeDone}), 0);
    rstN = 1'b1;
    // R1: counters start at zero, so no fresh needed for stripe 0
    runStripe(3, 32, 1'b0, 1'b0);
    runStripe(3, 32, 1'b0, 1'b0);   // R8 reads previous stripe
    runStripe(7, 64, 1'b1, 1'b0);
    runStripe(3, 32, 1'b0, 1'b1);   // R9 start while busy
    runStripe(4, 1, 1'b1, 1'b0);    // width 1 corner
    runStripe(4, 1, 1'b0, 1'b0);
    initM[3] = 1; widthM[3] = 32; initM[7] = 1; widthM[7] = 64;
    initM[4] = 1; widthM[4] = 1;
    // R10 rejected requests, then confirm slot 3 continues unchanged
    badStart(2, 40);
    badStart(3, 33);
    badStart(13, 8);
    badStart(8, 0);
    badStart(9, 65);
    runStripe(3, 32, 1'b0, 1'b0);
    // R6 wrap on slot 12 after 16 stripes, then fresh restart
    runStripe(12, 3, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) runStripe(12, 3, 1'b0, 1'b0);
    check(stripeM[12] == 1, "R6", "model wrap reached", stripeM[12], 1);
    runStripe(12, 3, 1'b1, 1'b0);
    initM[12] = 1; widthM[12] = 3;
    // random interleaving across slots
    for (int k = 0; k < 70; k++) begin
      int sel = int'($urandom % 13);
      bit fr = !initM[sel] || ($urandom % 8 == 0);
      if (fr) begin
        widthM[sel] = 1 + int'($urandom % capOf(sel));
        initM[sel] = 1;
      end
      runStripe(sel, widthM[sel], fr, ($urandom % 5 == 0));
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule